// File: doc/BRIEF.md
# Superframe-Aligned D Channel Byte Port

This block gives a processor byte-wide access to a low-rate serial D channel. When `port_en` is set, the one data address becomes a write-only transmit register and a read-only receive register. The transmitted D channel then comes only from the processor. The serial input from the pins is ignored. When `port_en` is clear, the pin-side serial input passes straight through to the line.

Both directions are double buffered and locked to the superframe. A written byte waits in a holding register and moves into the transmit shifter only on a superframe sync. It is then sent most significant bit first, one bit per `bit_strobe`. Received bits are collected most significant bit first. A completed byte moves to the readable holding register only on a sync. Each received byte raises an interrupt with source code 4'b1111. Reading the data register clears that code. After the read, an activation-status interrupt supplied by the surrounding logic becomes visible. Bytes pass through as raw bits: there is no flag detection, no bit stuffing and no CRC.

Top module: `dch_byte_port`

## Requirements
- R1: While `port_en`=1, a cycle with `wr_en`=1 stores `wr_data` as the transmit holding byte. `rd_data` always shows the receive holding byte. After reset, `rd_data`, `irq` and `irq_src` are 0.
- R2: While `port_en`=1, `line_tx_bit` comes from the transmit shifter and `pin_dch` has no effect on it. While `port_en`=0, `line_tx_bit` equals `pin_dch`.
- R3: The receive holding byte changes only at a rising clock edge where `port_en`=1 and `sf_sync`=1, and only if at least 8 `bit_strobe` cycles have occurred since the previous sync or enable. It then takes the last 8 received bits. A strobe in the same cycle as the sync counts as the first bit of the next byte.
- R4: On a cycle with `sf_sync`=1 and `port_en`=1, the transmit holding byte is copied into the shifter. A write during a superframe does not alter the byte being sent. If no write occurs, the same byte is sent again after the next sync.
- R5: After loading, `line_tx_bit` shows bit 7 of the byte. Each non-sync `bit_strobe` advances to the next lower bit. After 8 strobes the output is 0 until the next sync.
- R6: Each receive byte transfer sets `irq`=1 and `irq_src`=4'b1111.
- R7: A cycle with `rd_en`=1 and `port_en`=1 clears the 4'b1111 code, unless a transfer happens in the same cycle. Afterwards `irq` equals `act_irq`, and `irq_src` shows `act_code` when `act_irq`=1 and 4'b0000 otherwise.
- R8: Clearing `port_en` discards a partially received byte. Bits received before the disable never count toward a later transfer.
- R9: Data is carried without framing: the byte values 8'h7E and 8'hFF are received and transmitted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Selects register-sourced D channel |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Transmit byte from the processor |
| rd_en | input | 1 | Read strobe for the data register |
| rd_data | output | 8 | Receive holding byte |
| pin_dch | input | 1 | Pin-side serial D channel input |
| line_rx_bit | input | 1 | Received serial bit from the line |
| bit_strobe | input | 1 | One D channel bit time, both directions |
| sf_sync | input | 1 | Superframe sync flag |
| act_irq | input | 1 | Pending activation-status interrupt |
| act_code | input | 4 | Source code of the activation interrupt |
| line_tx_bit | output | 1 | Serial bit sent to the line |
| irq | output | 1 | Interrupt request |
| irq_src | output | 4 | Interrupt source nibble |

## Verification
The directed cases use fixed bytes. 8'hA5 shows bit order and 8'h3C written mid-superframe separates double buffering from direct loading. 8'h7E and 8'hFF show that no framing is applied. Short superframes of 5 bits, and a disable between two 4-bit halves, tell a correct bit count apart from one that keeps stale bits. The random phase varies strobe counts of 6 to 10 per superframe, strobes on the sync cycle, reads that collide with transfers, toggling pin data and activation interrupts. A bench model compares every output in every cycle.

// File: rtl/dch_byte_port.sv
module dch_byte_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         port_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         pin_dch,
  input  logic         line_rx_bit,
  input  logic         bit_strobe,
  input  logic         sf_sync,
  input  logic         act_irq,
  input  logic [3:0]   act_code,
  output logic         line_tx_bit,
  output logic         irq,
  output logic [3:0]   irq_src
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  tx_hold, tx_shift, rx_shift, rx_hold;
  logic [CW-1:0] rx_cnt;
  logic          dch_pend;
  logic          rx_xfer;

  assign rx_xfer     = port_en && sf_sync && (rx_cnt == FULL);
  assign rd_data     = rx_hold;
  assign line_tx_bit = port_en ? tx_shift[W-1] : pin_dch;
  assign irq         = dch_pend | act_irq;
  assign irq_src     = dch_pend ? 4'b1111 : (act_irq ? act_code : 4'b0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      tx_shift <= '0;
    end else begin
      if (port_en && wr_en) tx_hold <= wr_data;
      if (port_en && sf_sync) tx_shift <= tx_hold;
      else if (port_en && bit_strobe) tx_shift <= {tx_shift[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_shift <= '0;
      rx_cnt   <= '0;
      rx_hold  <= '0;
    end else begin
      if (rx_xfer) rx_hold <= rx_shift;
      if (!port_en) begin
        rx_cnt <= '0;
      end else begin
        if (sf_sync) rx_cnt <= bit_strobe ? CW'(1) : '0;
        else if (bit_strobe && rx_cnt != FULL) rx_cnt <= rx_cnt + CW'(1);
        if (bit_strobe) rx_shift <= {rx_shift[W-2:0], line_rx_bit};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dch_pend <= 1'b0;
    else if (rx_xfer) dch_pend <= 1'b1;
    else if (port_en && rd_en) dch_pend <= 1'b0;
  end

  p_hold_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && wr_en |=> tx_hold == $past(wr_data));

  p_sync_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && sf_sync |=> tx_shift == $past(tx_hold));

  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && bit_strobe && !sf_sync |=> tx_shift[W-1] == $past(tx_shift[W-2]));

  p_rx_on_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_hold) |-> $past(port_en && sf_sync));

  p_code_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer |=> irq && irq_src == 4'b1111);

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && rd_en && !rx_xfer |=> !dch_pend);

  p_disable_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> rx_cnt == '0);
endmodule

// File: tb/sim_dch_byte_port.sv
module sim_dch_byte_port;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, wr_en = 0, rd_en = 0, pin_dch = 0;
  logic line_rx_bit = 0, bit_strobe = 0, sf_sync = 0, act_irq = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] act_code = 0;
  logic [7:0] rd_data;
  logic line_tx_bit, irq;
  logic [3:0] irq_src;

  int checks = 0, errors = 0;
  logic [7:0] m_hold = 0, m_txs = 0, m_rxs = 0, m_rxh = 0;
  int m_cnt = 0;
  logic m_pend = 0;

  always #10 clk = ~clk;

  dch_byte_port u0 (.clk, .rst_n, .port_en, .wr_en, .wr_data, .rd_en, .rd_data,
    .pin_dch, .line_rx_bit, .bit_strobe, .sf_sync, .act_irq, .act_code,
    .line_tx_bit, .irq, .irq_src);

  function automatic logic exp_tx();
    return port_en ? m_txs[7] : pin_dch;
  endfunction
  function automatic logic [3:0] exp_src();
    return m_pend ? 4'b1111 : (act_irq ? act_code : 4'b0000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [7:0] old_hold;
    logic xfer;
    old_hold = m_hold;
    xfer = port_en && sf_sync && m_cnt == 8;
    if (port_en && wr_en) m_hold = wr_data;
    if (port_en && sf_sync) m_txs = old_hold;
    else if (port_en && bit_strobe) m_txs = {m_txs[6:0], 1'b0};
    if (xfer) m_rxh = m_rxs;
    if (!port_en) m_cnt = 0;
    else if (sf_sync) m_cnt = bit_strobe ? 1 : 0;
    else if (bit_strobe && m_cnt < 8) m_cnt++;
    if (port_en && bit_strobe) m_rxs = {m_rxs[6:0], line_rx_bit};
    if (xfer) m_pend = 1;
    else if (port_en && rd_en) m_pend = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
    chk("R2 R5 line_tx_bit", line_tx_bit, exp_tx());
    chk("R3 rd_data", rd_data, m_rxh);
    chk("R6 R7 irq", irq, m_pend | act_irq);
    chk("R6 R7 irq_src", irq_src, exp_src());
    wr_en = 0; rd_en = 0; bit_strobe = 0; sf_sync = 0;
  endtask

  task automatic rx_byte(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      line_rx_bit = b[7 - (i % 8)]; bit_strobe = 1; tick();
    end
  endtask

  task automatic sync();
    sf_sync = 1; tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset irq_src", irq_src, 0);

    pin_dch = 1; tick();
    chk("R2 disabled passthrough", line_tx_bit, 1);
    port_en = 1; tick();
    pin_dch = 0; tick(); pin_dch = 1; tick();
    chk("R2 pin ignored while enabled", line_tx_bit, 0);

    wr_en = 1; wr_data = 8'hA5; tick();
    sync();
    for (int i = 0; i < 8; i++) begin
      chk("R5 msb first bit", line_tx_bit, (8'hA5 >> (7 - i)) & 1);
      if (i == 3) begin wr_en = 1; wr_data = 8'h3C; end
      bit_strobe = 1; tick();
    end
    chk("R5 zero after 8 strobes", line_tx_bit, 0);
    sync();
    chk("R4 new byte after sync", line_tx_bit, 0);
    bit_strobe = 1; tick(); bit_strobe = 1; tick();
    chk("R4 bit2 of 3C", line_tx_bit, 1);
    sync(); bit_strobe = 1; tick(); bit_strobe = 1; tick();
    chk("R4 resend without write", line_tx_bit, 1);

    wr_en = 1; wr_data = 8'hFF; tick();
    sync();
    chk("R9 tx FF bit7", line_tx_bit, 1);
    rx_byte(8'h7E, 8);
    sync();
    chk("R9 rx 7E raw", rd_data, 8'h7E);
    chk("R6 code on byte", irq_src, 4'hF);
    chk("R6 irq on byte", irq, 1);
    act_irq = 1; act_code = 4'h5; tick();
    chk("R7 code still F before read", irq_src, 4'hF);
    rd_en = 1; tick();
    chk("R7 act code after read", irq_src, 4'h5);
    chk("R7 irq kept by act", irq, 1);
    act_irq = 0; tick();
    chk("R7 no source", irq_src, 0);

    rx_byte(8'hFF, 5);
    sync();
    chk("R3 partial byte no update", rd_data, 8'h7E);
    chk("R3 partial no irq", irq, 0);
    rx_byte(8'hF0, 4);
    port_en = 0; tick(); port_en = 1; tick();
    rx_byte(8'h0F, 4);
    sync();
    chk("R8 partial discarded on disable", rd_data, 8'h7E);
    rx_byte(8'hFF, 8);
    sync();
    chk("R9 rx FF raw", rd_data, 8'hFF);
    rd_en = 1; tick();

    for (int f = 0; f < 400; f++) begin
      int nb;
      nb = 6 + int'($urandom_range(4));
      for (int b = 0; b < nb; b++) begin
        line_rx_bit = 1'($urandom);
        pin_dch = 1'($urandom);
        bit_strobe = 1;
        if ($urandom_range(5) == 0) begin wr_en = 1; wr_data = 8'($urandom); end
        if ($urandom_range(7) == 0) rd_en = 1;
        if ($urandom_range(9) == 0) begin act_irq = ~act_irq; act_code = 4'($urandom); end
        tick();
        if ($urandom_range(2) == 0) tick();
      end
      if ($urandom_range(15) == 0) begin port_en = 0; tick(); tick(); port_en = 1; end
      sf_sync = 1;
      bit_strobe = 1'($urandom);
      line_rx_bit = 1'($urandom);
      if ($urandom_range(3) == 0) rd_en = 1;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule